// File: doc/BRIEF.md
# Page Write Sequencer for Byte-Wide Programmable Memory

This block sits between a client and a byte-wide non-volatile memory that takes writes one page at a time. The client streams byte beats over a valid/ready handshake. Each beat carries a page number, a byte offset inside the page, a data byte and a flag that marks the final byte. The sequencer turns each beat into one write-enable pulse. It drives the memory address, the data and the active-low chip-enable and write-enable lines, and it meets the setup, pulse-width and hold times, each counted in clocks.

Inside one page the memory accepts a byte load only if the next write-enable falling edge comes soon enough after the previous rising edge. The sequencer keeps every load inside that limit. A page closes when the client marks its last byte, when the client stalls past the limit, or when the page already holds its full count of bytes. Once the page is closed, the sequencer holds the strobes high past the limit, which makes the memory start its internal programming. It then waits a fixed program time with busy raised before it accepts the next page.

Top module: `pgw_seq`

## Requirements
- R1: While reset is asserted, and right after it is released, `mem_ce_n` and `mem_we_n` are high, `busy` is low, `s_ready` is high and `mem_addr` and `mem_data` are zero. Reset is asynchronous and takes effect even in the middle of a pulse.
- R2: Each accepted beat produces exactly one `mem_we_n` low pulse. The pulse lasts exactly PULSE_CLK cycles, and `mem_ce_n` is low for the whole of it.
- R3: `mem_addr` is the page number in bits [14:6] and the offset in bits [5:0]. The page number comes from the first beat of a page. The page field of every later beat in that page has no effect. Bytes are written in the order the client gives them, offsets in any order, with the data unchanged.
- R4: Address and data are stable for at least SETUP_CLK cycles before each `mem_we_n` falling edge. They do not change during the HOLD_CLK cycles that start at its rising edge, and they never change while `mem_ce_n` stays low.
- R5: Within a page, `mem_we_n` stays high for at most BLC_MAX_CLK cycles between consecutive pulses. A beat that arrives no later than BLC_MAX_CLK-SETUP_CLK-HOLD_CLK-1 cycles after `s_ready` returns continues the page.
- R6: If no beat arrives within that window, the page closes. `busy` rises HOLD_CLK+(BLC_MAX_CLK-SETUP_CLK-HOLD_CLK) cycles after the last rising edge.
- R7: A beat with `s_last` set closes its page. `busy` rises HOLD_CLK cycles after that beat's rising edge.
- R8: A page holds at most 64 bytes. The 65th beat of an unbroken stream is held off by `s_ready` low and then starts a new page after `busy` falls.
- R9: `busy` stays high for exactly BLC_MAX_CLK+1+PROG_CLK cycles. During that time both strobes are high and `s_ready` is low. `mem_we_n` has been high for more than BLC_MAX_CLK cycles before the program wait begins.
- R10: `s_ready` is high only while idle or between the loads of an open page. It is never high while `mem_ce_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Client beat valid |
| s_ready | output | 1 | Sequencer can take a beat |
| s_page | input | 9 | Page number, used on the first beat of a page |
| s_ofs | input | 6 | Byte offset within the page |
| s_data | input | 8 | Byte to write |
| s_last | input | 1 | Final byte of the page |
| mem_addr | output | 15 | Memory address {page, offset} |
| mem_data | output | 8 | Memory write data |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| busy | output | 1 | Page programming in progress |

## Verification
The bench places a beat in the last cycle of the byte-load window and another one cycle past it. A sequencer whose window is one cycle off would either lose the page to an early program trigger or let a load fall outside the limit. The bench also sends a stream of 70 beats and an exact 64-byte page, which catch a byte counter that splits a page early or lets it overflow. It varies the page field on beats after the first, which exposes a design that re-latches the page. Every pulse width, gap, setup, hold and busy length is timed at the pins, so a stretched pulse or a short program trigger shows up as a cycle count that differs from the expected one.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_PULSE = 3'd2,
    ST_HOLD  = 3'd3,
    ST_GAP   = 3'd4,
    ST_TRIG  = 3'd5,
    ST_PROG  = 3'd6
  } pgw_state_e;

  // Width needed to hold the values 0..n.
  function automatic int bits_for(input int n);
    int w = 1;
    for (int i = 1; i < 31; i++) begin
      if ((1 << w) <= n) w = i + 1;
    end
    return w;
  endfunction

  // Most cycles the sequencer may wait for a client beat between two
  // loads, so that hold + wait + setup stays inside the byte-load limit.
  function automatic int gap_budget(input int blc_max, input int setup_c, input int hold_c);
    return blc_max - setup_c - hold_c;
  endfunction

  // Cycles write-enable stays high in the trigger phase: past the limit.
  function automatic int trig_len(input int blc_max);
    return blc_max + 1;
  endfunction

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pgw_timer.sv
module pgw_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/pgw_beat_track.sv
module pgw_beat_track
  import pgw_pkg::*;
#(
  parameter int PAGE_W = 9,
  parameter int OFS_W  = 6,
  parameter int DATA_W = 8,
  localparam int PAGE_BYTES = 1 << OFS_W,
  localparam int CW = bits_for(PAGE_BYTES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    take,
  input  logic                    fresh,
  input  logic [PAGE_W-1:0]       s_page,
  input  logic [OFS_W-1:0]        s_ofs,
  input  logic [DATA_W-1:0]       s_data,
  input  logic                    s_last,
  output logic [PAGE_W+OFS_W-1:0] addr,
  output logic [DATA_W-1:0]       data,
  output logic                    page_end,
  output logic [CW-1:0]           byte_cnt,
  output logic                    first_beat
);

  localparam logic [CW-1:0] FULL = CW'(PAGE_BYTES);

  logic [PAGE_W-1:0] page_q;
  logic [OFS_W-1:0]  ofs_q;
  logic [DATA_W-1:0] data_q;
  logic              last_q;
  logic [CW-1:0]     cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      ofs_q  <= '0;
      data_q <= '0;
      last_q <= 1'b0;
      cnt_q  <= '0;
    end else if (take) begin
      ofs_q  <= s_ofs;
      data_q <= s_data;
      last_q <= s_last;
      if (fresh) begin
        page_q <= s_page;
        cnt_q  <= CW'(1);
      end else begin
        cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  assign addr       = {page_q, ofs_q};
  assign data       = data_q;
  assign byte_cnt   = cnt_q;
  assign first_beat = (cnt_q == CW'(1));
  assign page_end   = last_q || (cnt_q == FULL);

  // R3
  page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && !fresh |=> page_q == $past(page_q));

  // R8
  byte_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL);

endmodule

// File: rtl/pgw_fsm.sv
module pgw_fsm
  import pgw_pkg::*;
#(
  parameter int SETUP_CLK   = 2,
  parameter int PULSE_CLK   = 3,
  parameter int HOLD_CLK    = 1,
  parameter int BLC_MAX_CLK = 12,
  parameter int PROG_CLK    = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic s_valid,
  input  logic page_end,
  output logic s_ready,
  output logic take,
  output logic fresh,
  output logic ce_n,
  output logic we_n,
  output logic busy,
  output logic prog_start
);

  localparam int GAP_MAX  = gap_budget(BLC_MAX_CLK, SETUP_CLK, HOLD_CLK);
  localparam int TRIG_CLK = trig_len(BLC_MAX_CLK);
  localparam int LONGEST  = max_of(max_of(max_of(SETUP_CLK, PULSE_CLK),
                                          max_of(HOLD_CLK, GAP_MAX)),
                                   max_of(TRIG_CLK, PROG_CLK));
  localparam int TW = bits_for(LONGEST);

  if (GAP_MAX < 1 || SETUP_CLK < 1 || PULSE_CLK < 1 || HOLD_CLK < 1 || PROG_CLK < 1) begin : g_bad_timing
    $error("pgw_fsm: timing parameters leave no room for a byte-load gap");
  end

  pgw_state_e    state_q, state_d;
  logic          t_load, t_done;
  logic [TW-1:0] t_val;
  logic          ce_n_q, we_n_q, busy_q;

  pgw_timer #(.W(TW)) phase_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (t_load),
    .load_val(t_val),
    .expired (t_done)
  );

  always_comb begin
    state_d = state_q;
    t_load  = 1'b0;
    t_val   = '0;
    unique case (state_q)
      ST_IDLE: if (s_valid) begin
        state_d = ST_SETUP; t_load = 1'b1; t_val = TW'(SETUP_CLK - 1);
      end
      ST_SETUP: if (t_done) begin
        state_d = ST_PULSE; t_load = 1'b1; t_val = TW'(PULSE_CLK - 1);
      end
      ST_PULSE: if (t_done) begin
        state_d = ST_HOLD; t_load = 1'b1; t_val = TW'(HOLD_CLK - 1);
      end
      ST_HOLD: if (t_done) begin
        t_load = 1'b1;
        if (page_end) begin
          state_d = ST_TRIG; t_val = TW'(TRIG_CLK - 1);
        end else begin
          state_d = ST_GAP;  t_val = TW'(GAP_MAX - 1);
        end
      end
      ST_GAP: begin
        if (s_valid) begin
          state_d = ST_SETUP; t_load = 1'b1; t_val = TW'(SETUP_CLK - 1);
        end else if (t_done) begin
          state_d = ST_TRIG;  t_load = 1'b1; t_val = TW'(TRIG_CLK - 1);
        end
      end
      ST_TRIG: if (t_done) begin
        state_d = ST_PROG; t_load = 1'b1; t_val = TW'(PROG_CLK - 1);
      end
      ST_PROG: if (t_done) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ce_n_q  <= 1'b1;
      we_n_q  <= 1'b1;
      busy_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      ce_n_q  <= !(state_d inside {ST_SETUP, ST_PULSE, ST_HOLD});
      we_n_q  <= (state_d != ST_PULSE);
      busy_q  <= (state_d inside {ST_TRIG, ST_PROG});
    end
  end

  assign s_ready    = (state_q == ST_IDLE) || (state_q == ST_GAP);
  assign take       = s_ready && s_valid;
  assign fresh      = (state_q == ST_IDLE);
  assign prog_start = (state_q == ST_TRIG) && t_done;
  assign ce_n       = ce_n_q;
  assign we_n       = we_n_q;
  assign busy       = busy_q;

  // R10
  ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !s_ready);

  // R2
  strobe_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n_q |-> !ce_n_q);

endmodule

// File: rtl/pgw_seq.sv
module pgw_seq
  import pgw_pkg::*;
#(
  parameter int PAGE_W      = 9,
  parameter int OFS_W       = 6,
  parameter int DATA_W      = 8,
  parameter int SETUP_CLK   = 2,
  parameter int PULSE_CLK   = 3,
  parameter int HOLD_CLK    = 1,
  parameter int BLC_MAX_CLK = 12,
  parameter int PROG_CLK    = 40
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    s_valid,
  output logic                    s_ready,
  input  logic [PAGE_W-1:0]       s_page,
  input  logic [OFS_W-1:0]        s_ofs,
  input  logic [DATA_W-1:0]       s_data,
  input  logic                    s_last,
  output logic [PAGE_W+OFS_W-1:0] mem_addr,
  output logic [DATA_W-1:0]       mem_data,
  output logic                    mem_ce_n,
  output logic                    mem_we_n,
  output logic                    busy
);

  localparam int CW = bits_for(1 << OFS_W);
  localparam int HW = bits_for(2 * BLC_MAX_CLK + PULSE_CLK + 2);
  localparam int LW = bits_for(PULSE_CLK + 1);
  localparam logic [HW-1:0] BLC_LIM = HW'(BLC_MAX_CLK);
  localparam logic [LW-1:0] PW_EXP  = LW'(PULSE_CLK);

  // Events between the control and datapath halves, named for the checks.
  logic          take, fresh, page_end, prog_start, first_beat;
  logic [CW-1:0] byte_cnt;

  pgw_fsm #(
    .SETUP_CLK  (SETUP_CLK),
    .PULSE_CLK  (PULSE_CLK),
    .HOLD_CLK   (HOLD_CLK),
    .BLC_MAX_CLK(BLC_MAX_CLK),
    .PROG_CLK   (PROG_CLK)
  ) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .s_valid   (s_valid),
    .page_end  (page_end),
    .s_ready   (s_ready),
    .take      (take),
    .fresh     (fresh),
    .ce_n      (mem_ce_n),
    .we_n      (mem_we_n),
    .busy      (busy),
    .prog_start(prog_start)
  );

  pgw_beat_track #(
    .PAGE_W(PAGE_W),
    .OFS_W (OFS_W),
    .DATA_W(DATA_W)
  ) beat_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .fresh     (fresh),
    .s_page    (s_page),
    .s_ofs     (s_ofs),
    .s_data    (s_data),
    .s_last    (s_last),
    .addr      (mem_addr),
    .data      (mem_data),
    .page_end  (page_end),
    .byte_cnt  (byte_cnt),
    .first_beat(first_beat)
  );

  // Run-length counters of the write-enable level, saturating; they feed
  // only the timing properties below.
  logic [HW-1:0] hi_cnt;
  logic [LW-1:0] lo_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= '1;
      lo_cnt <= '0;
    end else if (mem_we_n) begin
      lo_cnt <= '0;
      if (hi_cnt != '1) hi_cnt <= hi_cnt + 1'b1;
    end else begin
      hi_cnt <= '0;
      if (lo_cnt != '1) lo_cnt <= lo_cnt + 1'b1;
    end
  end

  // R2
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> lo_cnt == PW_EXP);

  // R5
  gap_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) && !first_beat |-> hi_cnt <= BLC_LIM);

  // R9
  trigger_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |-> hi_cnt > BLC_LIM);

  // R4
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_n && $past(!mem_ce_n) |-> $stable(mem_addr) && $stable(mem_data));

  // R9
  idle_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> mem_we_n && mem_ce_n);

  // R8
  count_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && fresh |=> byte_cnt == CW'(1));

endmodule

// File: tb/pgw_seq_tb_top.sv
module pgw_seq_tb_top;

  localparam int SETUP_CLK   = 2;
  localparam int PULSE_CLK   = 3;
  localparam int HOLD_CLK    = 1;
  localparam int BLC_MAX_CLK = 12;
  localparam int PROG_CLK    = 40;
  localparam int WAIT_MAX    = BLC_MAX_CLK - HOLD_CLK - SETUP_CLK;
  localparam int BUSY_LEN    = PROG_CLK + BLC_MAX_CLK + 1;
  localparam int PAGE_BYTES  = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [8:0]  s_page = '0;
  logic [5:0]  s_ofs = '0;
  logic [7:0]  s_data = '0;
  logic        s_last = 1'b0;
  logic [14:0] mem_addr;
  logic [7:0]  mem_data;
  logic        mem_ce_n, mem_we_n, busy;

  always #4 clk = ~clk;

  pgw_seq #(
    .SETUP_CLK(SETUP_CLK), .PULSE_CLK(PULSE_CLK), .HOLD_CLK(HOLD_CLK),
    .BLC_MAX_CLK(BLC_MAX_CLK), .PROG_CLK(PROG_CLK)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_page(s_page), .s_ofs(s_ofs), .s_data(s_data), .s_last(s_last),
    .mem_addr(mem_addr), .mem_data(mem_data), .mem_ce_n(mem_ce_n),
    .mem_we_n(mem_we_n), .busy(busy)
  );

  typedef struct packed {
    logic [8:0] page;
    logic [7:0] nbytes;
    logic [7:0] wait_c;
    logic [7:0] stall_at;
    logic       last;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{9'h005, 8'd1,  8'd0,             8'd255, 1'b1},
    '{9'h1FF, 8'd8,  8'd0,             8'd255, 1'b1},
    '{9'h0A0, 8'd5,  8'(WAIT_MAX - 1), 8'd255, 1'b1},
    '{9'h033, 8'd6,  8'd0,             8'd255, 1'b0},
    '{9'h100, 8'd6,  8'd2,             8'd3,   1'b1},
    '{9'h077, 8'd64, 8'd0,             8'd255, 1'b1},
    '{9'h12C, 8'd70, 8'd1,             8'd255, 1'b1}
  };

  int checks = 0;
  int errors = 0;

  // Pin monitor state, written only by the monitor block.
  int          n_pulse = 0, ep_done = 0, ep_pulses = 0;
  int          hi_run = 1000, lo_run = 0, stab = 1000, busy_run = 0, trig_delay = 0;
  int          err_width = 0, err_gap = 0, err_setup = 0, err_hold = 0, err_busy = 0, err_rdy = 0;
  logic        prev_we = 1'b1, prev_busy = 1'b0;
  logic [14:0] prev_addr = '0;
  logic [7:0]  prev_data = '0;
  logic [14:0] got_addr [512];
  logic [7:0]  got_data [512];

  // Expected stream, written only by the driver.
  logic [14:0] exp_addr [512];
  logic [7:0]  exp_data [512];

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_we = 1'b1; prev_busy = 1'b0; prev_addr = '0; prev_data = '0;
      hi_run = 1000; lo_run = 0; stab = 1000; busy_run = 0; ep_pulses = 0;
    end else begin
      if (mem_we_n) hi_run = prev_we ? hi_run + 1 : 1;
      else          lo_run = prev_we ? 1 : lo_run + 1;
      if (mem_addr != prev_addr || mem_data != prev_data) begin
        if (!mem_we_n || hi_run < HOLD_CLK + 1) err_hold++;
        stab = 1;
      end else stab++;
      if (prev_we && !mem_we_n) begin
        if (stab <= SETUP_CLK) err_setup++;
        if (ep_pulses > 0 && hi_run > BLC_MAX_CLK) err_gap++;
        got_addr[n_pulse & 511] = mem_addr;
        got_data[n_pulse & 511] = mem_data;
        n_pulse++;
        ep_pulses++;
      end
      if (!prev_we && mem_we_n && lo_run != PULSE_CLK) err_width++;
      if (!mem_we_n && mem_ce_n) err_width++;
      if (busy && !prev_busy) begin
        trig_delay = hi_run - 1;
        busy_run = 0;
      end
      if (busy) begin
        busy_run++;
        if (!mem_we_n || !mem_ce_n || s_ready) err_busy++;
      end
      if (!busy && prev_busy) begin
        if (busy_run != BUSY_LEN) err_busy++;
        ep_done++;
        ep_pulses = 0;
      end
      if (s_ready && !mem_ce_n) err_rdy++;
      prev_we = mem_we_n; prev_busy = busy; prev_addr = mem_addr; prev_data = mem_data;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic run_vec(input vec_t v);
    int pbase = n_pulse;
    int ebase = ep_done;
    int cur = 0;
    int seg = 0;
    int mis = 0;
    int exp_end = v.last ? HOLD_CLK : HOLD_CLK + WAIT_MAX;
    for (int i = 0; i < int'(v.nbytes); i++) begin
      int wt = (i == 0) ? 0 : ((i == int'(v.stall_at)) ? WAIT_MAX : int'(v.wait_c));
      bit start = (i == 0) || (wt >= WAIT_MAX) || (cur == PAGE_BYTES);
      logic [8:0] pg;
      logic [5:0] ofs = 6'((i * 13 + 7) & 63);
      logic [7:0] dat = v.page[7:0] ^ 8'((i * 37 + 5) & 255);
      if (start && i != 0) seg++;
      if (start) cur = 0;
      cur++;
      pg = v.page + 9'(seg);
      exp_addr[(pbase + i) & 511] = {pg, ofs};
      exp_data[(pbase + i) & 511] = dat;
      while (!s_ready) @(negedge clk);
      repeat (wt) @(negedge clk);
      s_valid = 1'b1;
      s_page  = start ? pg : (pg ^ 9'h0F0);
      s_ofs   = ofs;
      s_data  = dat;
      s_last  = v.last && (i == int'(v.nbytes) - 1);
      while (!s_ready) @(negedge clk);
      @(negedge clk);
      s_valid = 1'b0;
      s_last  = 1'b0;
    end
    while (ep_done < ebase + seg + 1) @(negedge clk);
    @(negedge clk);
    chk(n_pulse - pbase == int'(v.nbytes), "R2", "pulse count", n_pulse - pbase, int'(v.nbytes));
    for (int i = 0; i < int'(v.nbytes); i++) begin
      if (got_addr[(pbase + i) & 511] != exp_addr[(pbase + i) & 511] ||
          got_data[(pbase + i) & 511] != exp_data[(pbase + i) & 511]) mis++;
    end
    chk(mis == 0, "R3", "address/data mismatches", mis, 0);
    chk(ep_done - ebase == seg + 1, "R6 R8", "pages programmed", ep_done - ebase, seg + 1);
    chk(trig_delay == exp_end, v.last ? "R7" : "R6", "cycles from last rise to busy", trig_delay, exp_end);
    chk(err_width == 0, "R2", "pulse width errors", err_width, 0);
    chk(err_gap == 0, "R5", "inter-pulse gap errors", err_gap, 0);
    chk(err_setup == 0, "R4", "setup errors", err_setup, 0);
    chk(err_hold == 0, "R4", "hold errors", err_hold, 0);
    chk(err_busy == 0, "R9", "busy phase errors", err_busy, 0);
    chk(err_rdy == 0, "R10", "ready during strobe", err_rdy, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R9 watchdog actual=hung expected=finished");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(mem_ce_n && mem_we_n && !busy, "R1", "strobes/busy in reset", {mem_ce_n, mem_we_n, busy}, 3'b110);
    rst_n = 1'b1;
    @(negedge clk);
    chk(s_ready == 1'b1, "R1", "ready after reset", s_ready, 1);
    chk(mem_addr == '0 && mem_data == '0, "R1", "address after reset", mem_addr, 0);

    for (int k = 0; k < NV; k++) run_vec(VECS[k]);

    // R1: reset in the middle of a write pulse
    while (!s_ready) @(negedge clk);
    s_valid = 1'b1; s_page = 9'h055; s_ofs = 6'd9; s_data = 8'hC3; s_last = 1'b1;
    @(negedge clk);
    s_valid = 1'b0; s_last = 1'b0;
    repeat (SETUP_CLK) @(negedge clk);
    chk(mem_we_n == 1'b0, "R2", "pulse under way", mem_we_n, 0);
    rst_n = 1'b0;
    #1;
    chk(mem_we_n && mem_ce_n && !busy, "R1", "strobes after async reset", {mem_ce_n, mem_we_n, busy}, 3'b110);
    chk(mem_addr == '0, "R1", "address after async reset", mem_addr, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(s_ready == 1'b1, "R10", "ready idle after reset", s_ready, 1);
    run_vec(VECS[0]);
    report();
  end

endmodule